// File: doc/BRIEF.md
# Wiper register bank with recall

This block holds the state of a 64-position digitally controlled potentiometer. It has one volatile 6-bit wiper register and four 6-bit data registers that stand in for nonvolatile storage. A serial front end decodes bus transactions into one-cycle command strobes. The bank acts on each strobe, drives a one-hot tap-select bus toward the resistor array, and returns read data on a registered output.

The wiper can be set in four ways: a direct write, a copy from any data register, single up/down steps that stop at either end of the range, and an automatic recall of data register 0 whenever reset is applied. A data register changes only through an explicit write or through a store of the current wiper. Both of these are refused while the write-protect input is low. An accepted store holds the bank busy for a programmable number of clock cycles, which models the nonvolatile write time. Every command that arrives during that window is dropped.

Top module: `wiper_bank`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper`. Code 0 selects the low-end tap and code 63 selects the high-end tap.
- R2: While `rst_n` is low, the wiper is loaded from data register 0 at each clock edge, and `rd_data` and `busy` clear. The data registers are not touched by reset. Their power-up contents come from parameter `INIT_VALS`, where register i sits in bits [6i+5:6i].
- R3: Op 1 (wiper write) loads `cmd_data` into the wiper. Op 2 (wiper read) copies the wiper into `rd_data`. Both take effect at the clock edge where `cmd_valid` is sampled high.
- R4: Op 3 (register write) loads `cmd_data` into the data register that `cmd_sel` selects. Op 4 (register read) copies that register into `rd_data`.
- R5: Op 5 (recall) copies the selected data register into the wiper and does not raise `busy`.
- R6: Op 6 (save) copies the wiper into the selected data register.
- R7: Op 7 (step) moves the wiper up by one when `cmd_data[0]` is 1 and down by one when it is 0. Op 0 does nothing.
- R8: A step up from 63 leaves the wiper at 63, and a step down from 0 leaves it at 0.
- R9: While `wp_n` is low, ops 3 and 6 change no data register and do not raise `busy`.
- R10: An accepted op 3 or op 6 raises `busy` for exactly `BUSY_CYCLES` clock cycles, starting right after the edge that accepted it.
- R11: While `busy` is high, every command is ignored. The wiper, `rd_data` and the data registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls data register 0 into the wiper |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (0 none, 1 wiper write, 2 wiper read, 3 register write, 4 register read, 5 recall, 6 save, 7 step) |
| cmd_sel | input | 2 | Data register index |
| cmd_data | input | 6 | Write data; bit 0 gives the step direction |
| wp_n | input | 1 | Write enable for the data registers, active high |
| rd_data | output | 6 | Result of the last accepted read |
| busy | output | 1 | Store timer running |
| wiper | output | 6 | Current wiper code |
| tap_sel | output | 64 | One-hot tap enable |

## Verification
The bench goes after both ends of the range. A design that wraps would show 0 after a step up from 63, or 63 after a step down from 0. It issues register writes and saves with protect low. A faulty bank would either change the stored value, which a later read shows, or raise `busy` for nothing. It counts the busy window cycle by cycle and sends a wiper write and a register read inside that window, to catch an off-by-one timer and commands that slip through. Last, it writes register 0 and then pulses reset, so that a bank which clears its data registers or recalls the wrong register gives a different wiper code.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WR_WIP = 3'd1,
    OP_RD_WIP = 3'd2,
    OP_WR_REG = 3'd3,
    OP_RD_REG = 3'd4,
    OP_RECALL = 3'd5,
    OP_SAVE   = 3'd6,
    OP_STEP   = 3'd7
  } op_e;

  // Saturating one-step move of an unsigned code of width w.
  function automatic logic [15:0] step_sat(input logic [15:0] val,
                                           input logic up,
                                           input int unsigned w);
    logic [15:0] top;
    top = 16'((32'd1 << w) - 1);
    if (up) return (val >= top) ? top : val + 16'd1;
    else    return (val == 16'd0) ? 16'd0 : val - 16'd1;
  endfunction

endpackage

// File: rtl/wb_busy_timer.sv
module wb_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (start)         remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/wb_reg_store.sv
module wb_reg_store #(
  parameter int WIDTH = 6,
  parameter int NREGS = 4,
  parameter logic [NREGS*WIDTH-1:0] INIT_VALS = '0,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_val,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_val,
  output logic [WIDTH-1:0] reg0
);
  logic [WIDTH-1:0] cells [NREGS];

  // Power-up contents; no reset term, so contents survive rst_n.
  initial begin
    for (int i = 0; i < NREGS; i++) cells[i] = INIT_VALS[i*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_val;
  end

  assign rd_val = cells[rd_idx];
  assign reg0   = cells[0];

endmodule

// File: rtl/wb_wiper_reg.sv
module wb_wiper_reg
  import wiper_bank_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] recall_val,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step_en,
  input  logic             step_up,
  output logic [WIDTH-1:0] wiper
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] stepped;
  assign stepped = WIDTH'(step_sat(16'(wiper), step_up, WIDTH));

  always_ff @(posedge clk) begin
    if (!rst_n)       wiper <= recall_val;
    else if (load_en) wiper <= load_val;
    else if (step_en) wiper <= stepped;
  end

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && step_up && wiper == TOP) |=> wiper == TOP);
  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !step_up && wiper == '0) |=> wiper == '0);

endmodule

// File: rtl/wb_tap_decode.sv
module wb_tap_decode #(
  parameter int WIDTH = 6,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic [WIDTH-1:0] code,
  output logic [TAPS-1:0]  tap_sel
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_sel[t] = (code == WIDTH'(t));
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int WIDTH       = 6,
  parameter int NREGS       = 4,
  parameter int BUSY_CYCLES = 1000,
  parameter logic [NREGS*WIDTH-1:0] INIT_VALS = '0,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDXW-1:0]  cmd_sel,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             wp_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             busy,
  output logic [WIDTH-1:0] wiper,
  output logic [TAPS-1:0]  tap_sel
);
  op_e op;
  assign op = op_e'(cmd_op);

  // Named command events
  logic accept, wip_write, wip_recall, wip_step, nv_req, nv_go;
  logic [WIDTH-1:0] reg_rd, reg0, nv_val, wip_load_val;

  assign accept     = cmd_valid && !busy;
  assign wip_write  = accept && op == OP_WR_WIP;
  assign wip_recall = accept && op == OP_RECALL;
  assign wip_step   = accept && op == OP_STEP;
  assign nv_req     = accept && (op == OP_WR_REG || op == OP_SAVE);
  assign nv_go      = nv_req && wp_n;
  assign nv_val     = (op == OP_SAVE) ? wiper : cmd_data;
  assign wip_load_val = wip_recall ? reg_rd : cmd_data;

  wb_reg_store #(.WIDTH(WIDTH), .NREGS(NREGS), .INIT_VALS(INIT_VALS)) u_store (
    .clk(clk), .wr_en(nv_go), .wr_idx(cmd_sel), .wr_val(nv_val),
    .rd_idx(cmd_sel), .rd_val(reg_rd), .reg0(reg0)
  );

  wb_wiper_reg #(.WIDTH(WIDTH)) u_wiper (
    .clk(clk), .rst_n(rst_n), .recall_val(reg0),
    .load_en(wip_write || wip_recall), .load_val(wip_load_val),
    .step_en(wip_step), .step_up(cmd_data[0]), .wiper(wiper)
  );

  wb_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(nv_go), .busy(busy)
  );

  wb_tap_decode #(.WIDTH(WIDTH)) u_decode (.code(wiper), .tap_sel(tap_sel));

  always_ff @(posedge clk) begin
    if (!rst_n)                          rd_data <= '0;
    else if (accept && op == OP_RD_WIP)  rd_data <= wiper;
    else if (accept && op == OP_RD_REG)  rd_data <= reg_rd;
  end

  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);
  // R9
  wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && !wp_n) |=> !busy);
  // R5
  recall_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip_recall |=> !busy);
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(wiper) && $stable(rd_data)));

endmodule

// File: tb/sim_wiper_bank.sv
`timescale 1ns/1ps
module sim_wiper_bank;
  localparam int BUSY = 8;
  localparam logic [23:0] INIT = {6'd40, 6'd30, 6'd20, 6'd10};

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_sel = '0;
  logic [5:0] cmd_data = '0;
  logic [5:0] rd_data, wiper;
  logic busy;
  logic [63:0] tap_sel;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  wiper_bank #(.BUSY_CYCLES(BUSY), .INIT_VALS(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .wp_n(wp_n), .rd_data(rd_data),
    .busy(busy), .wiper(wiper), .tap_sel(tap_sel)
  );

  // {op, sel, data, wp_n, expected wiper, expected rd_data}
  localparam logic [23:0] VEC [19] = '{
    {3'd2, 2'd0, 6'd0,  1'b1, 6'd10, 6'd10},  // R3 read wiper
    {3'd1, 2'd0, 6'd5,  1'b1, 6'd5,  6'd10},  // R3 write wiper
    {3'd7, 2'd0, 6'd1,  1'b1, 6'd6,  6'd10},  // R7 up
    {3'd7, 2'd0, 6'd0,  1'b1, 6'd5,  6'd10},  // R7 down
    {3'd5, 2'd2, 6'd0,  1'b1, 6'd30, 6'd10},  // R5 recall reg2
    {3'd4, 2'd1, 6'd0,  1'b1, 6'd30, 6'd20},  // R4 read reg1
    {3'd3, 2'd3, 6'd63, 1'b1, 6'd30, 6'd20},  // R4 write reg3
    {3'd4, 2'd3, 6'd0,  1'b1, 6'd30, 6'd63},  // R4 read back
    {3'd5, 2'd3, 6'd0,  1'b1, 6'd63, 6'd63},  // R5 recall reg3
    {3'd7, 2'd0, 6'd1,  1'b1, 6'd63, 6'd63},  // R8 top
    {3'd6, 2'd1, 6'd0,  1'b1, 6'd63, 6'd63},  // R6 save to reg1
    {3'd4, 2'd1, 6'd0,  1'b1, 6'd63, 6'd63},  // R6 read back
    {3'd1, 2'd0, 6'd0,  1'b1, 6'd0,  6'd63},  // R3
    {3'd7, 2'd0, 6'd0,  1'b1, 6'd0,  6'd63},  // R8 bottom
    {3'd3, 2'd0, 6'd7,  1'b0, 6'd0,  6'd63},  // R9 blocked write
    {3'd4, 2'd0, 6'd0,  1'b1, 6'd0,  6'd10},  // R9 reg0 intact
    {3'd6, 2'd2, 6'd0,  1'b0, 6'd0,  6'd10},  // R9 blocked save
    {3'd4, 2'd2, 6'd0,  1'b1, 6'd0,  6'd30},  // R9 reg2 intact
    {3'd0, 2'd0, 6'd0,  1'b1, 6'd0,  6'd30}   // R7 no-op
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_taps(input string req, input int code);
    logic [63:0] want;
    want = '0;
    want[code] = 1'b1;
    checks++;
    if (tap_sel !== want) begin
      fails++;
      $display("FAIL %s taps: actual %h expected %h", req, tap_sel, want);
    end
  endtask

  task automatic issue(input int op, input int sel, input int data, input bit wp);
    @(negedge clk);
    cmd_op = 3'(op); cmd_sel = 2'(sel); cmd_data = 6'(data); wp_n = wp;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; wp_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic string req_of(input int op);
    case (op)
      1, 2: return "R3";
      3, 4: return "R4";
      5:    return "R5";
      6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2", "wiper after reset", wiper, 10);
    check("R2", "rd_data after reset", rd_data, 0);
    check("R2", "busy after reset", busy, 0);
    check_taps("R1", 10);

    for (int i = 0; i < 19; i++) begin
      logic [23:0] v;
      v = VEC[i];
      issue(v[23:21], v[20:19], v[18:13], v[12]);
      wait_idle();
      check(req_of(v[23:21]), "wiper", wiper, v[11:6]);
      check(req_of(v[23:21]), "rd_data", rd_data, v[5:0]);
      check_taps("R1", v[11:6]);
    end

    // R8 directed: top end
    issue(1, 0, 62, 1);
    issue(7, 0, 1, 1);
    check("R8", "step to top", wiper, 63);
    issue(7, 0, 1, 1);
    check("R8", "step past top", wiper, 63);
    check_taps("R1", 63);

    // R9 directed: no busy on blocked write
    issue(3, 2, 1, 0);
    check("R9", "busy after blocked write", busy, 0);

    // R10 busy length on save
    begin
      int n;
      issue(6, 2, 0, 1);
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      check("R10", "busy cycles", n, BUSY);
    end
    issue(4, 2, 0, 1);
    check("R6", "saved wiper in reg2", rd_data, 63);

    // R11 commands during busy
    issue(3, 0, 44, 1);
    check("R10", "busy after register write", busy, 1);
    issue(1, 0, 5, 1);
    check("R11", "wiper held while busy", wiper, 63);
    issue(4, 1, 0, 1);
    check("R11", "rd_data held while busy", rd_data, 63);
    wait_idle();
    issue(4, 0, 0, 1);
    check("R4", "reg0 written", rd_data, 44);

    // R5 recall has no busy
    issue(1, 0, 9, 1);
    issue(5, 1, 0, 1);
    check("R5", "busy after recall", busy, 0);
    check("R5", "wiper after recall", wiper, 63);

    // R2 reset recalls reg0 and keeps data registers
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2", "wiper recalled from reg0", wiper, 44);
    check("R2", "rd_data cleared", rd_data, 0);
    check_taps("R1", 44);
    issue(4, 3, 0, 1);
    check("R2", "reg3 kept over reset", rd_data, 63);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule